// File: doc/BRIEF.md
# Pin Bank Direction and Output Controller

This block holds the direction and output state for a bank of 64 I/O pins and carries out single-pin instructions on that state. Each instruction names one pin and does one of two things. It either reads that pin's synchronized input bit and folds it into the carry or zero flag, or it writes a new value into the pin's direction bit, its output bit, or both. The value written can be a constant, a flag, an inverted flag, a random bit, or the inverse of the bit being replaced.

The execution stage of a processor drives the instruction fields, the current flags and an enable input. The enable already includes any condition-code decision. The block returns the flag values for the next instruction on the same cycle. Register writes take effect at the next rising clock edge. Pad circuitry and input synchronization are outside the block.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset, both the direction register and the output register are all zeros, so every pin is an input.
- R2: The pin number is 6 bits. It comes from `d_imm[5:0]` when `imm_sel` is 1 and from `d_reg[5:0]` when `imm_sel` is 0. The higher bits of the unused source have no effect.
- R3: An instruction is recognized when `sub_op[8:5]` is `0010`. Bits `[4:3]` give the group: 00 direction, 01 output, 10 float, 11 drive. With group 00 and exactly one of `wr_c`/`wr_z` set, the instruction is an input test and leaves both registers unchanged.
- R4: An input test takes `pin_in` of the selected pin and inverts it when `sub_op[0]` is 1. It then combines the result into the flag chosen by `wr_c` (C when 1, Z otherwise). `sub_op[2:1]` selects the combination: 00 copy, 01 AND, 10 OR, 11 XOR. The other flag keeps its value.
- R5: With group 00 and `wr_c` equal to `wr_z`, the instruction writes the selected direction bit only.
- R6: In every write group, `sub_op[2:0]` selects the new value: 0 gives 0, 1 gives 1, 2 gives C, 3 gives !C, 4 gives Z, 5 gives !Z, 6 gives the random bit, and 7 gives the inverse of the old target bit.
- R7: Group 01 writes the selected output bit only.
- R8: Group 10 (float) writes the output bit and clears the direction bit. Group 11 (drive) writes the output bit and sets the direction bit. For both, value 7 inverts the old output bit.
- R9: A write with both `wr_c` and `wr_z` set returns the old target bit in C and its inverse in Z. The old target bit is the direction bit for group 00 and the output bit for the other groups. A write with neither bit set leaves both flags unchanged.
- R10: While `en` is low, neither register changes and `nxt_c`/`nxt_z` equal `flag_c`/`flag_z`.
- R11: A `sub_op` that is not recognized changes no register and no flag.
- R12: `nxt_c`/`nxt_z` are combinational and valid in the same cycle as the instruction. Register writes become visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Instruction executes (condition already met) |
| wr_c | input | 1 | Instruction C-write bit |
| wr_z | input | 1 | Instruction Z-write bit |
| imm_sel | input | 1 | 1: pin from immediate field; 0: from register value |
| d_imm | input | 9 | Immediate destination field |
| d_reg | input | 32 | Destination register value |
| sub_op | input | 9 | Sub-operation field |
| flag_c | input | 1 | Current carry flag |
| flag_z | input | 1 | Current zero flag |
| rnd_bit | input | 1 | Random bit |
| pin_in | input | 64 | Synchronized pin inputs |
| dir_q | output | 64 | Direction register (1 = driven) |
| out_q | output | 64 | Output register |
| nxt_c | output | 1 | Carry flag after this instruction |
| nxt_z | output | 1 | Zero flag after this instruction |

## Verification
Flag results are combinational, so they are due in the cycle the instruction is presented. Register results are due one clock edge later. The bench drives each instruction on a falling edge and samples the flags 1 ns later. At that same point it confirms that neither register has moved yet. It then samples both registers 1 ns after the following rising edge. Each expected value comes from a register-level reference model in the bench. That model is built from the requirement rules and updated only after a step's checks are done.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

    typedef enum logic [1:0] {
        GRP_DIR = 2'd0,
        GRP_OUT = 2'd1,
        GRP_FLT = 2'd2,
        GRP_DRV = 2'd3
    } grp_e;

    // decoded instruction
    typedef struct packed {
        logic       valid;    // sub-op belongs to the pin family
        logic       is_test;  // input test rather than a write
        grp_e       grp;
        logic [2:0] sel;      // value / combine selector
        logic       tgt_c;    // test writes C (else Z)
        logic       ret;      // write returns old bit into flags
    } op_t;

endpackage

// File: rtl/pinctl_decode.sv
module pinctl_decode
    import pinctl_pkg::*;
#(
    parameter int OP_W = 9
) (
    input  logic [OP_W-1:0] sub_op,
    input  logic            wr_c,
    input  logic            wr_z,
    output op_t             op
);
    localparam logic [3:0] FAMILY = 4'b0010;

    always_comb begin
        op.valid   = (sub_op[OP_W-1:OP_W-4] == FAMILY);
        op.grp     = grp_e'(sub_op[4:3]);
        op.sel     = sub_op[2:0];
        op.is_test = (sub_op[4:3] == 2'b00) && (wr_c ^ wr_z);
        op.tgt_c   = wr_c;
        op.ret     = wr_c & wr_z;
    end
endmodule

// File: rtl/pinctl_index.sv
module pinctl_index #(
    parameter int PIN_W   = 6,
    parameter int FIELD_W = 9,
    parameter int D_W     = 32
) (
    input  logic               imm_sel,
    input  logic [FIELD_W-1:0] d_imm,
    input  logic [D_W-1:0]     d_reg,
    output logic [PIN_W-1:0]   pin
);
    // upper bits carry no meaning for pin selection
    logic unused_hi;
    assign unused_hi = ^{d_imm[FIELD_W-1:PIN_W], d_reg[D_W-1:PIN_W]};

    assign pin = imm_sel ? d_imm[PIN_W-1:0] : d_reg[PIN_W-1:0];
endmodule

// File: rtl/pinctl_value.sv
module pinctl_value (
    input  logic [2:0] sel,
    input  logic       flag_c,
    input  logic       flag_z,
    input  logic       rnd_bit,
    input  logic       old_bit,
    output logic       new_bit
);
    always_comb begin
        unique case (sel)
            3'd0:    new_bit = 1'b0;
            3'd1:    new_bit = 1'b1;
            3'd2:    new_bit = flag_c;
            3'd3:    new_bit = ~flag_c;
            3'd4:    new_bit = flag_z;
            3'd5:    new_bit = ~flag_z;
            3'd6:    new_bit = rnd_bit;
            default: new_bit = ~old_bit;
        endcase
    end
endmodule

// File: rtl/pinctl_flags.sv
module pinctl_flags
    import pinctl_pkg::*;
(
    input  logic en,
    input  op_t  op,
    input  logic in_bit,
    input  logic old_bit,
    input  logic flag_c,
    input  logic flag_z,
    output logic nxt_c,
    output logic nxt_z
);
    logic probe;
    logic cur;
    logic res;

    always_comb begin
        nxt_c = flag_c;
        nxt_z = flag_z;
        probe = in_bit ^ op.sel[0];
        cur   = op.tgt_c ? flag_c : flag_z;
        unique case (op.sel[2:1])
            2'b00:   res = probe;
            2'b01:   res = cur & probe;
            2'b10:   res = cur | probe;
            default: res = cur ^ probe;
        endcase
        if (en && op.valid) begin
            if (op.is_test) begin
                if (op.tgt_c) nxt_c = res;
                else          nxt_z = res;
            end else if (op.ret) begin
                nxt_c = old_bit;
                nxt_z = ~old_bit;
            end
        end
    end
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
    import pinctl_pkg::*;
#(
    parameter int PIN_W   = 6,
    parameter int FIELD_W = 9,
    parameter int D_W     = 32,
    parameter int OP_W    = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               wr_c,
    input  logic               wr_z,
    input  logic               imm_sel,
    input  logic [FIELD_W-1:0] d_imm,
    input  logic [D_W-1:0]     d_reg,
    input  logic [OP_W-1:0]    sub_op,
    input  logic               flag_c,
    input  logic               flag_z,
    input  logic               rnd_bit,
    input  logic [63:0]        pin_in,
    output logic [63:0]        dir_q,
    output logic [63:0]        out_q,
    output logic               nxt_c,
    output logic               nxt_z
);
    localparam int NPINS = 1 << PIN_W;

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] out;
    } bank_t;

    bank_t            bank_q, bank_d;
    op_t              op;
    logic [PIN_W-1:0] pin;
    logic             old_dir, old_out, old_tgt, new_bit;

    pinctl_decode #(.OP_W(OP_W)) u_dec (
        .sub_op (sub_op),
        .wr_c   (wr_c),
        .wr_z   (wr_z),
        .op     (op)
    );

    pinctl_index #(.PIN_W(PIN_W), .FIELD_W(FIELD_W), .D_W(D_W)) u_idx (
        .imm_sel (imm_sel),
        .d_imm   (d_imm),
        .d_reg   (d_reg),
        .pin     (pin)
    );

    assign old_dir = bank_q.dir[pin];
    assign old_out = bank_q.out[pin];
    assign old_tgt = (op.grp == GRP_DIR) ? old_dir : old_out;

    pinctl_value u_val (
        .sel     (op.sel),
        .flag_c  (flag_c),
        .flag_z  (flag_z),
        .rnd_bit (rnd_bit),
        .old_bit (old_tgt),
        .new_bit (new_bit)
    );

    pinctl_flags u_flg (
        .en      (en),
        .op      (op),
        .in_bit  (pin_in[pin]),
        .old_bit (old_tgt),
        .flag_c  (flag_c),
        .flag_z  (flag_z),
        .nxt_c   (nxt_c),
        .nxt_z   (nxt_z)
    );

    always_comb begin
        bank_d = bank_q;
        if (en && op.valid && !op.is_test) begin
            unique case (op.grp)
                GRP_DIR: bank_d.dir[pin] = new_bit;
                GRP_OUT: bank_d.out[pin] = new_bit;
                GRP_FLT: begin
                    bank_d.out[pin] = new_bit;
                    bank_d.dir[pin] = 1'b0;
                end
                default: begin
                    bank_d.out[pin] = new_bit;
                    bank_d.dir[pin] = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign dir_q = bank_q.dir;
    assign out_q = bank_q.out;

    // R10: disabled instruction leaves state alone
    a_r10_hold_regs: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(dir_q) && $stable(out_q)));
    a_r10_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (nxt_c == flag_c && nxt_z == flag_z));
    // R3: input tests never write a register
    a_r3_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sub_op[8:3] == 6'b001000 && (wr_c != wr_z)) |=> ($stable(dir_q) && $stable(out_q)));
    // R8: float clears, drive sets the direction bit
    a_r8_float_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sub_op[8:3] == 6'b001010) |=> (dir_q[$past(pin)] == 1'b0));
    a_r8_drive_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sub_op[8:3] == 6'b001011) |=> (dir_q[$past(pin)] == 1'b1));
    // R9: returned flags are complementary
    a_r9_ret_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sub_op[8:5] == 4'b0010 && wr_c && wr_z) |-> (nxt_z == !nxt_c));
    // R11: unrecognized sub-op is a no-op
    a_r11_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_op[8:5] != 4'b0010) |=> ($stable(dir_q) && $stable(out_q)));
    // R5: a single instruction touches at most one direction and one output bit
    a_r5_one_dir_bit: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(dir_q ^ $past(dir_q)) <= 1));
    a_r7_one_out_bit: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(out_q ^ $past(out_q)) <= 1));
endmodule

// File: tb/sim_pin_bank_ctrl.sv
`timescale 1ns/1ps
module sim_pin_bank_ctrl;
    localparam logic [63:0] PAT = 64'hA5F0_0F5A_3C96_C369;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, wr_c = 1'b0, wr_z = 1'b0, imm_sel = 1'b0;
    logic [8:0]  d_imm = '0, sub_op = '0;
    logic [31:0] d_reg = '0;
    logic        flag_c = 1'b0, flag_z = 1'b0, rnd_bit = 1'b0;
    logic [63:0] pin_in = PAT;
    logic [63:0] dir_q, out_q;
    logic        nxt_c, nxt_z;

    logic [63:0] m_dir = '0, m_out = '0;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    pin_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_c(wr_c), .wr_z(wr_z),
        .imm_sel(imm_sel), .d_imm(d_imm), .d_reg(d_reg), .sub_op(sub_op),
        .flag_c(flag_c), .flag_z(flag_z), .rnd_bit(rnd_bit), .pin_in(pin_in),
        .dir_q(dir_q), .out_q(out_q), .nxt_c(nxt_c), .nxt_z(nxt_z)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one instruction: flags checked same cycle, registers after the edge
    task automatic apply(input string tag, input bit c, input bit z, input bit l,
                         input logic [8:0] di, input logic [31:0] dr, input logic [8:0] so,
                         input bit fc, input bit fz, input bit rb, input bit e = 1'b1);
        logic [5:0]  p;
        logic [1:0]  g;
        logic [2:0]  v;
        logic        ec, ez, b, cur, r, old, nv;
        logic [63:0] ed, eo;
        p = l ? di[5:0] : dr[5:0];
        g = so[4:3]; v = so[2:0];
        ec = fc; ez = fz; ed = m_dir; eo = m_out;
        if (e && so[8:5] == 4'b0010) begin
            if (g == 2'b00 && (c ^ z)) begin
                b = PAT[p] ^ v[0];
                cur = c ? fc : fz;
                case (v[2:1])
                    2'b00: r = b;
                    2'b01: r = cur & b;
                    2'b10: r = cur | b;
                    default: r = cur ^ b;
                endcase
                if (c) ec = r; else ez = r;
            end else begin
                old = (g == 2'b00) ? m_dir[p] : m_out[p];
                case (v)
                    3'd0: nv = 1'b0;
                    3'd1: nv = 1'b1;
                    3'd2: nv = fc;
                    3'd3: nv = !fc;
                    3'd4: nv = fz;
                    3'd5: nv = !fz;
                    3'd6: nv = rb;
                    default: nv = !old;
                endcase
                case (g)
                    2'b00: ed[p] = nv;
                    2'b01: eo[p] = nv;
                    2'b10: begin eo[p] = nv; ed[p] = 1'b0; end
                    default: begin eo[p] = nv; ed[p] = 1'b1; end
                endcase
                if (c && z) begin ec = old; ez = !old; end
            end
        end
        @(negedge clk);
        en = e; wr_c = c; wr_z = z; imm_sel = l; d_imm = di; d_reg = dr;
        sub_op = so; flag_c = fc; flag_z = fz; rnd_bit = rb;
        #1;
        chk(tag, "nxt_c", {63'd0, nxt_c}, {63'd0, ec});
        chk(tag, "nxt_z", {63'd0, nxt_z}, {63'd0, ez});
        chk("R12", "dir before edge", dir_q, m_dir);
        chk("R12", "out before edge", out_q, m_out);
        @(posedge clk); #1;
        chk(tag, "dir_q", dir_q, ed);
        chk(tag, "out_q", out_q, eo);
        m_dir = ed; m_out = eo;
        en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "dir reset", dir_q, 64'd0);
        chk("R1", "out reset", out_q, 64'd0);
    endtask

    task automatic t_select;
        apply("R2", 0, 0, 1, 9'h1C5, 32'h0000_0000, 9'h041, 0, 0, 0);
        chk("R2", "imm pin 5 dir", {63'd0, dir_q[5]}, 64'd1);
        apply("R2", 0, 0, 0, 9'h005, 32'hFFFF_FFC9, 9'h041, 0, 0, 0);
        chk("R2", "reg pin 9 dir", {63'd0, dir_q[9]}, 64'd1);
        apply("R2", 0, 0, 0, 9'h03F, 32'h0000_0080, 9'h049, 0, 0, 0);
        chk("R2", "reg pin 0 out", {63'd0, out_q[0]}, 64'd1);
    endtask

    task automatic t_tests;
        for (int p = 0; p < 4; p++)
            for (int v = 0; v < 8; v++)
                for (int t = 0; t < 2; t++)
                    for (int f = 0; f < 4; f++)
                        apply("R3 R4", t[0], !t[0], 1, 9'(p), 32'd0,
                              {6'b001000, 3'(v)}, f[0], f[1], 0);
    endtask

    task automatic t_dir;
        for (int v = 0; v < 8; v++)
            for (int f = 0; f < 4; f++)
                apply("R5 R6", 0, 0, 1, 9'(16 + v), 32'd0, {6'b001000, 3'(v)}, f[0], f[1], f[1]);
    endtask

    task automatic t_out;
        for (int v = 0; v < 8; v++)
            for (int f = 0; f < 4; f++)
                apply("R7 R6", 0, 0, 0, 9'd0, 32'(24 + v), {6'b001001, 3'(v)}, f[1], f[0], f[0]);
    endtask

    task automatic t_fltdrv;
        apply("R8", 0, 0, 1, 9'd40, 32'd0, 9'h059, 0, 0, 0);
        apply("R8", 0, 0, 1, 9'd40, 32'd0, 9'h057, 0, 0, 0);
        chk("R8", "float not out", {63'd0, out_q[40]}, 64'd0);
        apply("R8", 0, 0, 1, 9'd41, 32'd0, 9'h05F, 0, 0, 0);
        chk("R8", "drive not dir", {63'd0, dir_q[41]}, 64'd1);
        for (int v = 0; v < 8; v++) begin
            apply("R8", 0, 0, 1, 9'(42 + v), 32'd0, {6'b001010, 3'(v)}, 1, 0, 1);
            apply("R8", 0, 0, 1, 9'(42 + v), 32'd0, {6'b001011, 3'(v)}, 0, 1, 0);
        end
    endtask

    task automatic t_ret;
        apply("R9", 0, 0, 1, 9'd50, 32'd0, 9'h041, 0, 0, 0);
        apply("R9", 1, 1, 1, 9'd50, 32'd0, 9'h040, 0, 1, 0);
        apply("R9", 1, 1, 1, 9'd50, 32'd0, 9'h049, 1, 0, 0);
        apply("R9", 1, 1, 1, 9'd50, 32'd0, 9'h050, 0, 0, 0);
        apply("R9", 1, 1, 1, 9'd51, 32'd0, 9'h05F, 1, 1, 0);
        apply("R9", 1, 1, 1, 9'd51, 32'd0, 9'h05F, 0, 0, 0);
        apply("R9", 0, 0, 1, 9'd51, 32'd0, 9'h04F, 1, 0, 0);
    endtask

    task automatic t_disabled;
        apply("R10", 0, 0, 1, 9'd60, 32'd0, 9'h041, 1, 0, 0, 0);
        apply("R10", 1, 1, 1, 9'd16, 32'd0, 9'h05F, 0, 1, 0, 0);
        apply("R10", 1, 0, 1, 9'd0, 32'd0, 9'h040, 0, 1, 0, 0);
        chk("R10", "pin 60 still input", {63'd0, dir_q[60]}, 64'd0);
    endtask

    task automatic t_unknown;
        apply("R11", 1, 1, 1, 9'd61, 32'd0, 9'h000, 1, 0, 0);
        apply("R11", 0, 0, 1, 9'd61, 32'd0, 9'h061, 1, 0, 0);
        apply("R11", 1, 0, 1, 9'd61, 32'd0, 9'h0C1, 0, 1, 0);
        apply("R11", 1, 1, 1, 9'd61, 32'd0, 9'h1FF, 0, 0, 1);
        chk("R11", "pin 61 untouched", {62'd0, dir_q[61], out_q[61]}, 64'd0);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL R12 watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #11 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset;
        t_select;
        t_tests;
        t_dir;
        t_out;
        t_fltdrv;
        t_ret;
        t_disabled;
        t_unknown;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule